// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits beside a processor core and decides which interrupt level, if any, the core should take next. It folds fifteen level-sensitive external request lines and the core's software-interrupt register into one 16-bit pending vector. It then scans that vector from the top level down. The winner becomes a trap index of the external-interrupt type, together with a hard-interrupt request level for the core.

The core supplies its current trap index every cycle. The arbiter only replaces that index when no trap is outstanding, or when the outstanding trap is itself an external interrupt, so a higher external level can pre-empt a lower one. When nothing is pending and an external-interrupt index is still in place, the index is cleared and the request is withdrawn. A one-cycle wake pulse accompanies any newly raised external line, so a halted core resumes.

Top module: `pil_arbiter`

## Requirements
- R1: Line `ext_irq[n]` (n = 1..15) is captured into pending level n on each clock edge; it contributes to arbitration from the following cycle and stops contributing in the cycle after it falls.
- R2: `wake` is high for the cycle after an edge at which some `ext_irq` line is high while its captured pending bit was low, and is low otherwise.
- R3: The pending vector is the OR of the captured external bits, `soft_int[15:1]` at their own levels, and `soft_int[0]` (the timer bit) moved to level 14; `soft_int[0]` never counts as level 0.
- R4: The winning level is the highest set bit of the pending vector among levels 15 down to 1; level 0 is never chosen.
- R5: When `cur_idx` is neither zero nor of the external-interrupt type (`cur_idx[8:4]` equal to 4), the next `int_idx` equals `cur_idx` and `hard_req` keeps its value.
- R6: When a level is pending and `cur_idx` is zero or external-type, the next `int_idx` is 0x40 ORed with the winning level; `hard_req` is set to 1 if that value differs from `cur_idx` and otherwise keeps its value.
- R7: When the pending vector is zero and `cur_idx` is external-type, the next `int_idx` is 0 and `hard_req` is 0.
- R8: A synchronous active-high `rst` sets `int_idx`, `hard_req`, `wake` and all captured pending bits to zero.
- R9: When the pending vector is zero and `cur_idx` is not external-type, the next `int_idx` equals `cur_idx` and `hard_req` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 15 | External request lines, bit n is level n (1..15) |
| soft_int | input | 16 | Software-interrupt register; bit 0 is the timer bit |
| cur_idx | input | 9 | Core's current trap index |
| int_idx | output | 9 | Updated trap index, registered |
| hard_req | output | 1 | Hard-interrupt request level to the core |
| wake | output | 1 | One-cycle pulse that clears the core's halted state |

## Verification
The assertions take `cur_idx` as the core's view of the index for the cycle in which it is presented. They place no constraint on how it relates to `int_idx`, so any 9-bit value must be handled. The stimulus draws `cur_idx` from four pools: zero, the fed-back `int_idx`, random external-type values, and arbitrary values. This covers the pre-emption, blocked and cleared paths. External lines and software bits are drawn sparse so that single-level winners, including the timer remap to level 14, occur often. Directed cases pin down the equal-index hold of `hard_req` and the clear path.

// File: rtl/pil_arbiter.sv
module pil_arbiter #(
  parameter int              LEVELS      = 16,
  parameter int              IDX_W       = 9,
  parameter int              TIMER_BIT   = 0,
  parameter int              TIMER_LEVEL = 14,
  parameter logic [IDX_W-1:0] EXT_BASE   = 9'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:1] ext_irq,
  input  logic [LEVELS-1:0] soft_int,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  int_idx,
  output logic              hard_req,
  output logic              wake
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam logic [IDX_W-1:0] TYPE_MASK = ~IDX_W'(LEVELS - 1);

  logic [LEVELS-1:1] pend_q;
  logic [LEVELS-1:0] soft_vec, timer_vec, eff;
  logic [LVL_W-1:0]  win;
  logic [IDX_W-1:0]  cand;
  logic              any_hit, is_ext, may_set;

  always_comb begin
    timer_vec = '0;
    timer_vec[TIMER_LEVEL] = soft_int[TIMER_BIT];
    soft_vec = soft_int;
    soft_vec[TIMER_BIT] = 1'b0;
  end

  assign eff = {pend_q, 1'b0} | soft_vec | timer_vec;

  always_comb begin
    win = '0;
    for (int i = 1; i < LEVELS; i++)
      if (eff[i]) win = LVL_W'(i);
  end

  assign any_hit = |eff[LEVELS-1:1];
  assign cand    = EXT_BASE | IDX_W'(win);
  assign is_ext  = (cur_idx & TYPE_MASK) == EXT_BASE;
  assign may_set = (cur_idx == '0) || is_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      wake     <= 1'b0;
      int_idx  <= '0;
      hard_req <= 1'b0;
    end else begin
      pend_q <= ext_irq;
      wake   <= |(ext_irq & ~pend_q);
      if (any_hit && may_set) begin
        int_idx <= cand;
        if (cand != cur_idx) hard_req <= 1'b1;
      end else if (!(|eff) && is_ext) begin
        int_idx  <= '0;
        hard_req <= 1'b0;
      end else begin
        int_idx <= cur_idx;
      end
    end
  end

  AST_WAKE_ON_NEW_LINE: assert property (@(posedge clk) disable iff (rst)
    (|(ext_irq & ~pend_q)) |=> wake); // R2
  AST_BLOCKED_PASS: assert property (@(posedge clk) disable iff (rst)
    (cur_idx != '0 && !is_ext) |=> (int_idx == $past(cur_idx) && $stable(hard_req))); // R5
  AST_EXT_FORM: assert property (@(posedge clk) disable iff (rst)
    (any_hit && may_set) |=> ((int_idx & TYPE_MASK) == EXT_BASE && int_idx[LVL_W-1:0] != '0)); // R4
  AST_CLEAR_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (eff == '0 && is_ext) |=> (int_idx == '0 && !hard_req)); // R7
  AST_REQ_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_req) |-> (int_idx != $past(cur_idx))); // R6
endmodule

// File: tb/sim_pil_arbiter.sv
`timescale 1ns/1ps
module sim_pil_arbiter;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:1] ext_irq;
  logic [15:0] soft_int;
  logic [8:0]  cur_idx;
  logic [8:0]  int_idx;
  logic        hard_req, wake;

  int checks = 0;
  int errors = 0;

  logic [15:1] m_pend;
  logic        m_req;

  always #2.5 clk = ~clk;

  pil_arbiter u0 (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .soft_int(soft_int),
    .cur_idx(cur_idx), .int_idx(int_idx), .hard_req(hard_req), .wake(wake)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pending(input logic [15:1] p, input logic [15:0] s);
    logic [15:0] v;
    v = {p, 1'b0} | (s & 16'hFFFE);
    if (s[0]) v[14] = 1'b1;
    return v;
  endfunction

  function automatic int top_level(input logic [15:0] v);
    for (int i = 15; i >= 1; i--)
      if (v[i]) return i;
    return 0;
  endfunction

  task automatic step(input logic [15:1] e, input logic [15:0] s,
                      input logic [8:0] c, input string force_tag);
    logic [15:0] v;
    logic [8:0]  e_idx;
    logic        e_wake, is_ext;
    string       tag;
    v      = pending(m_pend, s);
    is_ext = (c[8:4] == 5'h4);
    if (v[15:1] != 0 && (c == 0 || is_ext)) begin
      e_idx = 9'h040 | 9'(top_level(v));
      if (e_idx != c) m_req = 1'b1;
      tag = "R6";
    end else if (v == 0 && is_ext) begin
      e_idx = 9'h000;
      m_req = 1'b0;
      tag = "R7";
    end else if (v == 0) begin
      e_idx = c;
      tag = "R9";
    end else begin
      e_idx = c;
      tag = "R5";
    end
    if (force_tag != "") tag = force_tag;
    e_wake = |(e & ~m_pend);
    m_pend = e;
    @(negedge clk);
    ext_irq = e; soft_int = s; cur_idx = c;
    @(posedge clk);
    #1;
    chk(tag, "int_idx", int'(int_idx), int'(e_idx));
    chk(tag, "hard_req", int'(hard_req), int'(m_req));
    chk("R2", "wake", int'(wake), int'(e_wake));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; ext_irq = '0; soft_int = 16'h0001; cur_idx = 9'h045;
    m_pend = '0; m_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "int_idx", int'(int_idx), 0);
    chk("R8", "hard_req", int'(hard_req), 0);
    chk("R8", "wake", int'(wake), 0);
    @(negedge clk);
    rst = 1'b0; soft_int = '0; cur_idx = '0;

    step(15'h0000, 16'h0001, 9'h000, "R3");
    step(15'h0000, 16'h8001, 9'h04E, "R4");
    step(15'h0000, 16'h0000, 9'h04F, "R7");
    step(15'h0001, 16'h0000, 9'h000, "R2");
    step(15'h0001, 16'h0000, 9'h000, "R1");
    step(15'h0000, 16'h0000, 9'h041, "R1");
    step(15'h0000, 16'h0000, 9'h041, "R7");
    step(15'h0001, 16'h0000, 9'h000, "R9");
    step(15'h0001, 16'h0000, 9'h041, "R6");
    step(15'h4000, 16'h0000, 9'h068, "R5");
    step(15'h4000, 16'h0000, 9'h068, "R5");
    step(15'h0000, 16'h0200, 9'h000, "R3");
    step(15'h0000, 16'h0001, 9'h043, "R3");
    step(15'h7FFF, 16'h0000, 9'h000, "R2");
    step(15'h0000, 16'h0000, 9'h04F, "R4");

    for (int n = 0; n < 3000; n++) begin
      logic [15:1] e;
      logic [15:0] s;
      logic [8:0]  c;
      e = 15'($urandom() & $urandom() & $urandom());
      s = 16'($urandom() & $urandom() & $urandom() & $urandom());
      case ($urandom_range(0, 3))
        0: c = 9'h000;
        1: c = int_idx;
        2: c = 9'h040 | 9'($urandom_range(0, 15));
        default: c = 9'($urandom());
      endcase
      step(e, s, c, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule